// File: doc/BRIEF.md
# Verdict-Gated Packet Hold Buffer

This block sits between an ingress packet stream and an egress port. Every packet accepted at ingress gets the next value of a 16-bit wrapping sequence number as its tag, and its words are written into a slot of an on-chip buffer. At the same time a tagged copy of each word is sent out on the inspection lane of one sensor. The sensor is picked by a stateless XOR fold of the packet's flow key, so every packet of a flow reaches the same sensor and no per-flow table is needed.

Stored packets stay in the buffer until a verdict arrives. A verdict names a tag, says pass or drop, and either covers only that tag or is cumulative. A cumulative verdict covers every undecided packet of the issuing sensor, from the oldest held tag up to the named one. Passed packets leave on egress as bursts in tag order. Dropped packets are freed and never transmitted. A per-entry age counter drops any complete packet that still has no verdict after a programmable number of cycles. When every slot is in use, ingress applies backpressure instead of discarding packets.

Top module: `verdict_hold_buffer`

## Requirements
- R1: Packets are tagged 0, 1, 2, ... in arrival order, modulo 2^16. Every word of a packet is copied to the inspection port one cycle after it is accepted, with that tag on `insp_id_o` and `insp_last_o` marking the final word.
- R2: The inspection lane is the XOR of the flow key folded into log2(NUM_SENSORS)-bit chunks. It is taken from the first word. With two sensors, lane 1 is used when the 16-bit key has odd parity and lane 0 otherwise. At most one lane is valid in any cycle.
- R3: A stored packet never appears on egress before a pass verdict covers it.
- R4: After a pass verdict, the packet appears on egress as consecutive valid words. Word k carries the data that was stored as word k, `out_id_o` carries the packet's tag, and `out_last_o` is set on the final word only.
- R5: A single drop verdict frees the packet without any egress word.
- R6: A cumulative pass from sensor s (`vd_cum_i`=1, `vd_pass_i`=1, `vd_sensor_i`=s) marks for forwarding every held, undecided packet of sensor s whose tag lies between the oldest held tag and `vd_id_i` inclusive. Packets of other sensors are not affected.
- R7: A cumulative drop selects the same set as R6 and discards all of it.
- R8: Egress follows tag order. A packet that is passed early waits until every older held packet has been sent or dropped.
- R9: When DEPTH packets are held, `in_ready_o` is low and no packet is lost. Ingress resumes once a slot is freed.
- R10: A complete packet with no verdict after `timeout_cfg_i` cycles is dropped and `timeout_o` pulses. A value of 0 disables the timeout.
- R11: A verdict whose tag is not held, or a single verdict for a packet that is already decided, changes nothing and pulses `vd_err_o` one cycle later.
- R12: After reset, `in_ready_o` is high and no inspection, egress, error or timeout output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Ingress word valid |
| in_ready_o | output | 1 | Ingress can accept a word |
| in_data_i | input | DATA_W | Ingress word |
| in_last_i | input | 1 | Final word of the packet |
| in_flow_i | input | KEY_W | Flow key, sampled on the first word |
| insp_valid_o | output | NUM_SENSORS | One-hot inspection lane valid |
| insp_data_o | output | DATA_W | Inspection copy of the word |
| insp_last_o | output | 1 | Final word of the inspection copy |
| insp_id_o | output | ID_W | Tag of the inspected packet |
| vd_valid_i | input | 1 | Verdict valid |
| vd_pass_i | input | 1 | 1 = forward, 0 = drop |
| vd_cum_i | input | 1 | 1 = cumulative verdict |
| vd_id_i | input | ID_W | Tag named by the verdict |
| vd_sensor_i | input | log2(NUM_SENSORS) | Sensor issuing a cumulative verdict |
| timeout_cfg_i | input | AGE_W | Verdict timeout in cycles, 0 = off |
| out_valid_o | output | 1 | Egress word valid |
| out_data_o | output | DATA_W | Egress word |
| out_last_o | output | 1 | Final egress word of the packet |
| out_id_o | output | ID_W | Tag of the egress packet |
| timeout_o | output | 1 | Pulse: a packet was dropped on timeout |
| vd_err_o | output | 1 | Pulse: a verdict was rejected |

## Verification
The assertions check, on every cycle, that inspection lanes are one-hot and that inspection tags step by one per packet. They also check that the hold count never exceeds DEPTH, that an egress burst has no gaps once it has started, and that egress tags only move forward. Only the bench scenarios can show the verdict semantics: that held packets stay put, that cumulative verdicts pick exactly one sensor's packets up to a tag, that drops and timeouts leave nothing on egress, and that rejected verdicts have no effect.

// File: rtl/holdbuf_pkg.sv
package holdbuf_pkg;
  typedef enum logic {EG_IDLE, EG_SEND} eg_state_e;
endpackage

// File: rtl/holdbuf_flow_hash.sv
module holdbuf_flow_hash #(
  parameter int KEY_W = 16,
  parameter int SEL_W = 1
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam int CHUNKS = (KEY_W + SEL_W - 1) / SEL_W;
  localparam int PAD_W  = CHUNKS * SEL_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(key_i);

  always_comb begin
    sel_o = '0;
    for (int c = 0; c < CHUNKS; c++) sel_o ^= padded[c*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/holdbuf_entry.sv
module holdbuf_entry #(
  parameter int LEN_W   = 3,
  parameter int MAX_LEN = 4,
  parameter int AGE_W   = 12,
  parameter int SEL_W   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             word_i,
  input  logic             last_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             free_i,
  input  logic             hit_i,
  input  logic             pass_i,
  input  logic [AGE_W-1:0] tmo_cfg_i,
  output logic             occ_o,
  output logic             cmp_o,
  output logic             dec_o,
  output logic             pass_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [LEN_W-1:0] len_o,
  output logic             tmo_o
);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN);

  logic [AGE_W-1:0] age_q;
  logic             tmo_hit;

  assign tmo_hit = occ_o & cmp_o & ~dec_o & (tmo_cfg_i != '0) & (age_q >= tmo_cfg_i);
  assign tmo_o   = tmo_hit & ~hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_o  <= 1'b0;
      cmp_o  <= 1'b0;
      dec_o  <= 1'b0;
      pass_o <= 1'b0;
      sel_o  <= '0;
      len_o  <= '0;
      age_q  <= '0;
    end else if (alloc_i) begin
      occ_o  <= 1'b1;
      cmp_o  <= last_i;
      dec_o  <= 1'b0;
      pass_o <= 1'b0;
      sel_o  <= sel_i;
      len_o  <= LEN_W'(1);
      age_q  <= '0;
    end else if (free_i) begin
      occ_o  <= 1'b0;
      cmp_o  <= 1'b0;
      dec_o  <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      if (word_i) begin
        if (len_o != LEN_SAT) len_o <= len_o + LEN_W'(1);
        if (last_i) cmp_o <= 1'b1;
      end
      if (hit_i) begin
        dec_o  <= 1'b1;
        pass_o <= pass_i;
      end else if (tmo_hit) begin
        dec_o  <= 1'b1;
        pass_o <= 1'b0;
      end
      if (cmp_o && !dec_o && age_q != '1) age_q <= age_q + AGE_W'(1);
    end
  end
endmodule

// File: rtl/verdict_hold_buffer.sv
module verdict_hold_buffer
  import holdbuf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int KEY_W       = 16,
  parameter int ID_W        = 16,
  parameter int DEPTH       = 8,
  parameter int MAX_WORDS   = 4,
  parameter int NUM_SENSORS = 2,
  parameter int AGE_W       = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  input  logic [DATA_W-1:0]              in_data_i,
  input  logic                           in_last_i,
  input  logic [KEY_W-1:0]               in_flow_i,
  output logic [NUM_SENSORS-1:0]         insp_valid_o,
  output logic [DATA_W-1:0]              insp_data_o,
  output logic                           insp_last_o,
  output logic [ID_W-1:0]                insp_id_o,
  input  logic                           vd_valid_i,
  input  logic                           vd_pass_i,
  input  logic                           vd_cum_i,
  input  logic [ID_W-1:0]                vd_id_i,
  input  logic [$clog2(NUM_SENSORS)-1:0] vd_sensor_i,
  input  logic [AGE_W-1:0]               timeout_cfg_i,
  output logic                           out_valid_o,
  output logic [DATA_W-1:0]              out_data_o,
  output logic                           out_last_o,
  output logic [ID_W-1:0]                out_id_o,
  output logic                           timeout_o,
  output logic                           vd_err_o
);
  // DEPTH and NUM_SENSORS must be powers of two; slot = low tag bits
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int SEL_W  = $clog2(NUM_SENSORS);
  localparam int LEN_W  = $clog2(MAX_WORDS + 1);
  localparam int IDX_W  = $clog2(MAX_WORDS);

  // ---------------- ingress ----------------
  logic [ID_W-1:0]   head_id_q, next_id_q, pkt_id_q, occ;
  logic              in_busy_q, full, accept, alloc, store;
  logic [LEN_W-1:0]  wr_idx_q, cur_idx;
  logic [SEL_W-1:0]  pkt_sel_q, hash_sel, cur_sel;
  logic [ID_W-1:0]   cur_id;
  logic [SLOT_W-1:0] wr_slot, head_slot;

  assign occ        = next_id_q - head_id_q;
  assign full       = (occ == ID_W'(DEPTH));
  assign in_ready_o = in_busy_q | ~full;
  assign accept     = in_valid_i & in_ready_o;
  assign alloc      = accept & ~in_busy_q;
  assign cur_id     = in_busy_q ? pkt_id_q  : next_id_q;
  assign cur_sel    = in_busy_q ? pkt_sel_q : hash_sel;
  assign cur_idx    = in_busy_q ? wr_idx_q  : '0;
  assign wr_slot    = cur_id[SLOT_W-1:0];
  assign store      = accept & (cur_idx < LEN_W'(MAX_WORDS));

  holdbuf_flow_hash #(.KEY_W(KEY_W), .SEL_W(SEL_W)) u_hash (
    .key_i(in_flow_i),
    .sel_o(hash_sel)
  );

  logic pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_busy_q <= 1'b0;
      pkt_id_q  <= '0;
      pkt_sel_q <= '0;
      wr_idx_q  <= '0;
      next_id_q <= '0;
      head_id_q <= '0;
    end else begin
      if (accept) begin
        in_busy_q <= ~in_last_i;
        pkt_id_q  <= cur_id;
        pkt_sel_q <= cur_sel;
        wr_idx_q  <= (cur_idx == LEN_W'(MAX_WORDS)) ? cur_idx : cur_idx + LEN_W'(1);
      end
      if (alloc) next_id_q <= next_id_q + ID_W'(1);
      if (pop)   head_id_q <= head_id_q + ID_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insp_valid_o <= '0;
      insp_data_o  <= '0;
      insp_last_o  <= 1'b0;
      insp_id_o    <= '0;
    end else begin
      for (int s = 0; s < NUM_SENSORS; s++)
        insp_valid_o[s] <= accept & (cur_sel == SEL_W'(s));
      if (accept) begin
        insp_data_o <= in_data_i;
        insp_last_o <= in_last_i;
        insp_id_o   <= cur_id;
      end
    end
  end

  // ---------------- storage ----------------
  logic [DATA_W-1:0] mem_q [DEPTH][MAX_WORDS];
  logic [LEN_W-1:0]  rd_idx_q;

  always_ff @(posedge clk_i) begin
    if (store) mem_q[wr_slot][cur_idx[IDX_W-1:0]] <= in_data_i;
  end

  // ---------------- entries and verdict decode ----------------
  logic [DEPTH-1:0] ent_occ, ent_cmp, ent_dec, ent_pass, ent_tmo, hit;
  logic [SEL_W-1:0] ent_sel [DEPTH];
  logic [LEN_W-1:0] ent_len [DEPTH];
  logic [ID_W-1:0]  v_off;
  logic             in_win;
  logic [SLOT_W-1:0] v_slot;

  assign head_slot = head_id_q[SLOT_W-1:0];
  assign v_off     = vd_id_i - head_id_q;
  assign in_win    = v_off < occ;
  assign v_slot    = vd_id_i[SLOT_W-1:0];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic [SLOT_W-1:0] off;
    logic              cum_hit, one_hit;
    assign off     = SLOT_W'(j) - head_slot;
    assign cum_hit = ent_occ[j] & ~ent_dec[j] & (ent_sel[j] == vd_sensor_i)
                   & (off <= v_off[SLOT_W-1:0]);
    assign one_hit = (v_slot == SLOT_W'(j)) & ~ent_dec[j];
    assign hit[j]  = vd_valid_i & in_win & (vd_cum_i ? cum_hit : one_hit);

    holdbuf_entry #(
      .LEN_W(LEN_W), .MAX_LEN(MAX_WORDS), .AGE_W(AGE_W), .SEL_W(SEL_W)
    ) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (alloc & (wr_slot == SLOT_W'(j))),
      .word_i   (accept & in_busy_q & (wr_slot == SLOT_W'(j))),
      .last_i   (in_last_i),
      .sel_i    (cur_sel),
      .free_i   (pop & (head_slot == SLOT_W'(j))),
      .hit_i    (hit[j]),
      .pass_i   (vd_pass_i),
      .tmo_cfg_i(timeout_cfg_i),
      .occ_o    (ent_occ[j]),
      .cmp_o    (ent_cmp[j]),
      .dec_o    (ent_dec[j]),
      .pass_o   (ent_pass[j]),
      .sel_o    (ent_sel[j]),
      .len_o    (ent_len[j]),
      .tmo_o    (ent_tmo[j])
    );
  end

  logic vd_bad;
  assign vd_bad = vd_valid_i & (~in_win | (~vd_cum_i & ent_dec[v_slot]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_err_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      vd_err_o  <= vd_bad;
      timeout_o <= |ent_tmo;
    end
  end

  // ---------------- egress, strictly in tag order ----------------
  eg_state_e eg_q;
  logic      head_ready, rd_last;

  assign head_ready = (occ != '0) & ent_cmp[head_slot] & ent_dec[head_slot];
  assign rd_last    = (rd_idx_q + LEN_W'(1)) == ent_len[head_slot];
  assign pop        = (eg_q == EG_IDLE) ? (head_ready & ~ent_pass[head_slot])
                                        : rd_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eg_q        <= EG_IDLE;
      rd_idx_q    <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
      out_id_o    <= '0;
    end else begin
      out_valid_o <= (eg_q == EG_SEND);
      out_last_o  <= (eg_q == EG_SEND) & rd_last;
      out_data_o  <= mem_q[head_slot][rd_idx_q[IDX_W-1:0]];
      out_id_o    <= head_id_q;
      if (eg_q == EG_IDLE) begin
        if (head_ready && ent_pass[head_slot]) begin
          eg_q     <= EG_SEND;
          rd_idx_q <= '0;
        end
      end else begin
        rd_idx_q <= rd_idx_q + LEN_W'(1);
        if (rd_last) eg_q <= EG_IDLE;
      end
    end
  end
endmodule

// File: rtl/verdict_hold_buffer_chk.sv
module verdict_hold_buffer_chk #(
  parameter int ID_W        = 16,
  parameter int DEPTH       = 8,
  parameter int NUM_SENSORS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_SENSORS-1:0] insp_valid_o,
  input logic                   insp_last_o,
  input logic [ID_W-1:0]        insp_id_o,
  input logic                   out_valid_o,
  input logic                   out_last_o,
  input logic [ID_W-1:0]        out_id_o,
  input logic [ID_W-1:0]        occ_i
);
  logic            insp_mid_q, insp_seen_q, eg_mid_q, eg_seen_q;
  logic [ID_W-1:0] insp_prev_q, eg_prev_q, eg_diff;
  logic            insp_first, eg_first;

  assign insp_first = (|insp_valid_o) & ~insp_mid_q;
  assign eg_first   = out_valid_o & ~eg_mid_q;
  assign eg_diff    = out_id_o - eg_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insp_mid_q  <= 1'b0;
      insp_seen_q <= 1'b0;
      insp_prev_q <= '0;
      eg_mid_q    <= 1'b0;
      eg_seen_q   <= 1'b0;
      eg_prev_q   <= '0;
    end else begin
      if (|insp_valid_o) insp_mid_q <= ~insp_last_o;
      if (insp_first) begin
        insp_seen_q <= 1'b1;
        insp_prev_q <= insp_id_o;
      end
      if (out_valid_o) eg_mid_q <= ~out_last_o;
      if (eg_first) begin
        eg_seen_q <= 1'b1;
        eg_prev_q <= out_id_o;
      end
    end
  end

  // R2
  insp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(insp_valid_o));

  // R1
  insp_id_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insp_first && insp_seen_q |-> insp_id_o == insp_prev_q + ID_W'(1));

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= ID_W'(DEPTH));

  // R4
  burst_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_last_o |=> out_valid_o);

  // R4
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  // R8
  egress_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eg_first && eg_seen_q |-> eg_diff != '0 && eg_diff < ID_W'(DEPTH * 2));
endmodule

bind verdict_hold_buffer verdict_hold_buffer_chk #(
  .ID_W(ID_W), .DEPTH(DEPTH), .NUM_SENSORS(NUM_SENSORS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insp_valid_o(insp_valid_o),
  .insp_last_o (insp_last_o),
  .insp_id_o   (insp_id_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_id_o    (out_id_o),
  .occ_i       (occ)
);

// File: tb/verdict_hold_buffer_bench.sv
`timescale 1ns/1ps
module verdict_hold_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_last_i = 1'b0, in_ready_o;
  logic [15:0] in_data_i = '0, in_flow_i = '0;
  logic [1:0]  insp_valid_o;
  logic [15:0] insp_data_o, insp_id_o;
  logic        insp_last_o;
  logic        vd_valid_i = 1'b0, vd_pass_i = 1'b0, vd_cum_i = 1'b0;
  logic [15:0] vd_id_i = '0;
  logic        vd_sensor_i = 1'b0;
  logic [11:0] timeout_cfg_i = '0;
  logic        out_valid_o, out_last_o, timeout_o, vd_err_o;
  logic [15:0] out_data_o, out_id_o;

  always #2.5 clk = ~clk;

  verdict_hold_buffer u_verdict_hold_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .in_flow_i(in_flow_i),
    .insp_valid_o(insp_valid_o), .insp_data_o(insp_data_o),
    .insp_last_o(insp_last_o), .insp_id_o(insp_id_o),
    .vd_valid_i(vd_valid_i), .vd_pass_i(vd_pass_i), .vd_cum_i(vd_cum_i),
    .vd_id_i(vd_id_i), .vd_sensor_i(vd_sensor_i), .timeout_cfg_i(timeout_cfg_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .out_id_o(out_id_o), .timeout_o(timeout_o), .vd_err_o(vd_err_o)
  );

  int checks = 0, errors = 0;

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitors
  int          n_insp = 0, n_eg = 0, n_err = 0, n_tmo = 0;
  logic [15:0] insp_id_log [64];
  logic        insp_sel_log [64];
  logic [15:0] eg_id_log [64];
  int          eg_len_log [64];
  logic        insp_mid = 1'b0, eg_mid = 1'b0;
  int          widx = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (vd_err_o) n_err++;
      if (timeout_o) n_tmo++;
      if (|insp_valid_o) begin
        if (!insp_mid && n_insp < 64) begin
          insp_id_log[n_insp]  = insp_id_o;
          insp_sel_log[n_insp] = insp_valid_o[1];
          n_insp++;
        end
        insp_mid = !insp_last_o;
      end
      if (out_valid_o) begin
        if (!eg_mid && n_eg < 64) begin
          eg_id_log[n_eg]  = out_id_o;
          eg_len_log[n_eg] = 0;
          n_eg++;
          widx = 0;
        end
        chk_eq("R4 egress word", {16'h0, out_data_o}, {16'h0, out_id_o[7:0], 8'(widx)});
        widx++;
        if (n_eg > 0) eg_len_log[n_eg-1]++;
        eg_mid = !out_last_o;
      end
    end
  end

  int next_id = 0;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] flow, input int len, output logic [15:0] id);
    id = 16'(next_id);
    next_id++;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_flow_i  = flow;
      in_data_i  = {id[7:0], 8'(k)};
      in_last_i  = (k == len - 1);
      while (!in_ready_o) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic verdict(input logic pass, input logic cum, input logic [15:0] id, input logic s);
    @(negedge clk);
    vd_valid_i  = 1'b1;
    vd_pass_i   = pass;
    vd_cum_i    = cum;
    vd_id_i     = id;
    vd_sensor_i = s;
    @(negedge clk);
    vd_valid_i = 1'b0;
  endtask

  // flow[31:16], length[15:8], pass[0]
  localparam logic [31:0] VEC [6] = '{
    {16'h0001, 8'd1, 8'd1},
    {16'h0003, 8'd4, 8'd1},
    {16'h00F0, 8'd2, 8'd0},
    {16'h8001, 8'd3, 8'd1},
    {16'h0007, 8'd4, 8'd0},
    {16'h1234, 8'd2, 8'd1}
  };

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] id, a, b, c, d, e, f, g, t, u;
    logic [15:0] p [9];
    int n0, e0;

    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12
    chk_eq("R12 ready", in_ready_o, 1);
    chk_eq("R12 egress", out_valid_o, 0);
    chk_eq("R12 inspection", insp_valid_o, 0);
    chk_eq("R12 err/timeout", {vd_err_o, timeout_o}, 0);

    // table walk: R1 R2 R3 R4 R5
    foreach (VEC[i]) begin
      n0 = n_eg;
      send(VEC[i][31:16], int'(VEC[i][15:8]), id);
      wait_cyc(3);
      chk_eq("R1 tag", insp_id_log[n_insp-1], id);
      chk_eq("R2 lane", insp_sel_log[n_insp-1], ^VEC[i][31:16]);
      chk_eq("R3 held", n_eg, n0);
      verdict(VEC[i][0], 1'b0, id, 1'b0);
      wait_cyc(15);
      if (VEC[i][0]) begin
        chk_eq("R4 count", n_eg, n0 + 1);
        chk_eq("R4 tag", eg_id_log[n0], id);
        chk_eq("R4 length", eg_len_log[n0], VEC[i][15:8]);
      end else begin
        chk_eq("R5 dropped", n_eg, n0);
      end
    end

    // R8 ordering, R11 repeated verdict
    n0 = n_eg;
    send(16'h0001, 2, a);
    send(16'h0003, 2, b);
    verdict(1'b1, 1'b0, b, 1'b0);
    wait_cyc(15);
    chk_eq("R8 waits behind older", n_eg, n0);
    e0 = n_err;
    verdict(1'b1, 1'b0, b, 1'b0);
    wait_cyc(3);
    chk_eq("R11 decided twice", n_err, e0 + 1);
    verdict(1'b1, 1'b0, a, 1'b0);
    wait_cyc(20);
    chk_eq("R8 count", n_eg, n0 + 2);
    chk_eq("R8 first", eg_id_log[n0], a);
    chk_eq("R8 second", eg_id_log[n0+1], b);

    // R6 cumulative pass, sensor 1 (flow 1) vs sensor 0 (flow 3)
    n0 = n_eg;
    send(16'h0001, 3, c);
    send(16'h0003, 1, f);
    send(16'h0001, 2, d);
    send(16'h0001, 2, e);
    verdict(1'b1, 1'b1, d, 1'b1);
    wait_cyc(15);
    chk_eq("R6 count", n_eg, n0 + 1);
    chk_eq("R6 first", eg_id_log[n0], c);
    verdict(1'b1, 1'b0, f, 1'b0);
    wait_cyc(20);
    chk_eq("R6 after other sensor", n_eg, n0 + 3);
    chk_eq("R6 order f", eg_id_log[n0+1], f);
    chk_eq("R6 order d", eg_id_log[n0+2], d);

    // R7 cumulative drop of e
    verdict(1'b0, 1'b1, e, 1'b1);
    wait_cyc(10);
    send(16'h0003, 1, g);
    verdict(1'b1, 1'b0, g, 1'b0);
    wait_cyc(15);
    chk_eq("R7 count", n_eg, n0 + 4);
    chk_eq("R7 next", eg_id_log[n0+3], g);

    // R11 unheld tags
    n0 = n_eg;
    e0 = n_err;
    verdict(1'b1, 1'b0, 16'(next_id + 5), 1'b0);
    verdict(1'b1, 1'b0, a, 1'b0);
    verdict(1'b0, 1'b1, 16'(next_id), 1'b1);
    wait_cyc(3);
    chk_eq("R11 errors", n_err, e0 + 3);
    chk_eq("R11 no effect", n_eg, n0);

    // R10 timeout
    chk_eq("R10 disabled at zero", n_tmo, 0);
    timeout_cfg_i = 12'd30;
    n0 = n_eg;
    send(16'h0001, 2, t);
    wait_cyc(80);
    chk_eq("R10 pulse", n_tmo, 1);
    chk_eq("R10 no egress", n_eg, n0);
    send(16'h0003, 1, u);
    verdict(1'b1, 1'b0, u, 1'b0);
    wait_cyc(15);
    chk_eq("R10 next passes", eg_id_log[n0], u);
    timeout_cfg_i = '0;

    // R9 full
    n0 = n_eg;
    for (int k = 0; k < 8; k++) send(16'h0001, 1, p[k]);
    wait_cyc(2);
    chk_eq("R9 backpressure", in_ready_o, 0);
    chk_eq("R9 held", n_eg, n0);
    verdict(1'b1, 1'b1, p[7], 1'b1);
    send(16'h0001, 2, p[8]);
    verdict(1'b1, 1'b0, p[8], 1'b0);
    wait_cyc(40);
    chk_eq("R9 count", n_eg, n0 + 9);
    chk_eq("R9 first", eg_id_log[n0], p[0]);
    chk_eq("R9 last", eg_id_log[n0+8], p[8]);
    chk_eq("R9 ready again", in_ready_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule